// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small set-associative store that keeps the first two instructions found at the target of a taken branch. When the fetch stage redirects to a target address, it presents that address as a lookup. On a hit, the block returns both target instructions one cycle later. The fetch stage can then queue them a cycle ahead of what the main instruction cache would deliver. On a miss the block reports no hit. Once the main instruction cache has produced the two target instructions, the fetch stage writes them back as a fill.

The store has 64 entries, arranged as 16 sets of four ways. The set is chosen by four low-order bits of the word-aligned target address, and the remaining upper bits form the tag. When a set is full, a three-bit tree pseudo-LRU per set picks the way to replace. Two control inputs are driven from software state. One keeps the cache switched off. The other clears every entry in a single cycle.

Top module: `tgt_insn_cache`

## Requirements
- R1: The cache holds 16 sets of 4 ways. The set index is address bits [5:2] and the tag is address bits [31:6]. Entries in different sets never affect one another.
- R2: Lookups are registered. `hit_o` and the instruction outputs reflect the lookup presented one cycle earlier. `hit_o` is 0 in any cycle that follows a cycle without `lk_valid`.
- R3: A hit returns the two instructions last filled for that address: `insn0_o` holds the first and `insn1_o` the second. On a miss, `hit_o` is 0 and both instruction outputs are zero.
- R4: A fill whose tag is already present in its set overwrites that way. Otherwise it takes the lowest-numbered invalid way in the set.
- R5: When all four ways of a set are valid, the victim comes from a 3-bit tree. Bit 0 = 0 selects ways 0/1, and then bit 1 picks way 1 when set. Bit 0 = 1 selects ways 2/3, and then bit 2 picks way 3 when set. Every lookup hit and every fill to a way w sets bit 0 to NOT w[1], and sets bit 1 (for w < 2) or bit 2 (for w >= 2) to NOT w[0]. The tree starts at 000 after reset or a flush. When a lookup hit and a fill touch the same set in one cycle, the lookup's update is applied first.
- R6: While `ctl_disable` is 1, every lookup reports a miss and fills are ignored.
- R7: A cycle with `ctl_flush` high clears every valid bit, so all later lookups miss until new fills arrive.
- R8: A fill in the same cycle as `ctl_flush` is dropped.
- R9: A lookup in the same cycle as a fill or flush sees the contents from before that cycle.
- R10: After reset all entries are invalid and `hit_o`, `insn0_o` and `insn1_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Branch target address to look up |
| fill_valid | input | 1 | Write a target instruction pair |
| fill_addr | input | 32 | Target address of the fill |
| fill_insn0 | input | 32 | First target instruction |
| fill_insn1 | input | 32 | Second target instruction |
| ctl_disable | input | 1 | Cache off: lookups miss, fills dropped |
| ctl_flush | input | 1 | Invalidate all entries |
| hit_o | output | 1 | Lookup of previous cycle hit |
| insn0_o | output | 32 | First target instruction on hit, else 0 |
| insn1_o | output | 32 | Second target instruction on hit, else 0 |

## Verification
On every cycle the assertions check several properties. A hit only follows a request. Outputs are zero on a miss. A disabled cycle never yields a hit, and a flush leaves no valid entry. At most one way matches a tag, and a fill both sets the valid bit of the way it chose and picks a free way whenever one exists. Other behaviour can only be shown by the bench's scenarios, which compare against an independent model of the set contents: the returned instruction data, the exact victim order of the tree replacement, fills dropped while disabled or under a flush, and a lookup that races a fill to the same address.

// File: rtl/tic_pkg.sv
package tic_pkg;
  // Tree replacement is defined for exactly four ways.
  localparam int WAYS = 4;
  localparam int WAY_W = 2;

  // Way the tree points at as the next victim.
  function automatic logic [WAY_W-1:0] plru_victim(input logic [2:0] tree);
    if (!tree[0]) return tree[1] ? 2'd1 : 2'd0;
    else          return tree[2] ? 2'd3 : 2'd2;
  endfunction

  // Point the tree away from the way just used.
  function automatic logic [2:0] plru_touch(input logic [2:0] tree, input logic [WAY_W-1:0] way);
    logic [2:0] nxt;
    nxt = tree;
    nxt[0] = ~way[1];
    if (!way[1]) nxt[1] = ~way[0];
    else         nxt[2] = ~way[0];
    return nxt;
  endfunction
endpackage

// File: rtl/tic_way_match.sv
module tic_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            key,
  output logic [WAYS-1:0]             match,
  output logic                        any,
  output logic [$clog2(WAYS)-1:0]     way
);
  localparam int WW = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == key);
  end

  assign any = |match;

  always_comb begin
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) way = WW'(w);
  end

  // R4: fills replace a matching way, so a tag never sits in two ways
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/tic_victim_sel.sv
module tic_victim_sel
  import tic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [WAYS-1:0]   valid,
  input  logic [2:0]        tree,
  output logic [WAY_W-1:0]  way_sel
);
  logic [WAY_W-1:0] free_way;
  logic             has_free;

  always_comb begin
    free_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid[w]) begin
        free_way = WAY_W'(w);
        has_free = 1'b1;
      end
  end

  always_comb begin
    if (hit)           way_sel = hit_way;
    else if (has_free) way_sel = free_way;
    else               way_sel = plru_victim(tree);
  end

  // R4: a free way is always used before anything is evicted
  assert_free_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !(&valid)) |-> !valid[way_sel]);
endmodule

// File: rtl/tgt_insn_cache.sv
module tgt_insn_cache
  import tic_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [INSN_W-1:0] fill_insn0,
  input  logic [INSN_W-1:0] fill_insn1,
  input  logic              ctl_disable,
  input  logic              ctl_flush,
  output logic              hit_o,
  output logic [INSN_W-1:0] insn0_o,
  output logic [INSN_W-1:0] insn1_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [WAYS-1:0]                vld_q  [SETS];
  logic [2:0]                     plru_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]     tag_q  [SETS];
  logic [WAYS-1:0][INSN_W-1:0]    d0_q   [SETS];
  logic [WAYS-1:0][INSN_W-1:0]    d1_q   [SETS];

  // Address split: word offset dropped, index above it, tag on top.
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             unused_lowbits;
  assign lk_idx   = lk_addr[2 +: IDX_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[2 +: IDX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign unused_lowbits = ^{lk_addr[1:0], fill_addr[1:0]};

  // Named internal events for the assertions.
  logic [WAYS-1:0]  lk_match, fill_match;
  logic             lk_any, fill_any, lk_hit, fill_we, any_valid;
  logic [WAY_W-1:0] lk_way, fill_hit_way, fill_way;
  logic [2:0]       plru_after_lk, fill_tree_base;

  tic_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .valid(vld_q[lk_idx]), .tags(tag_q[lk_idx]),
    .key(lk_tag), .match(lk_match), .any(lk_any), .way(lk_way));

  tic_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .clk(clk), .rst_n(rst_n), .valid(vld_q[fill_idx]), .tags(tag_q[fill_idx]),
    .key(fill_tag), .match(fill_match), .any(fill_any), .way(fill_hit_way));

  assign lk_hit  = lk_valid && !ctl_disable && lk_any;
  assign fill_we = fill_valid && !ctl_disable && !ctl_flush;

  // Lookup touch is applied before the fill touch of the same set.
  assign plru_after_lk  = lk_hit ? plru_touch(plru_q[lk_idx], lk_way) : plru_q[lk_idx];
  assign fill_tree_base = (lk_hit && lk_idx == fill_idx) ? plru_after_lk : plru_q[fill_idx];

  tic_victim_sel u_victim (
    .clk(clk), .rst_n(rst_n), .hit(fill_any), .hit_way(fill_hit_way),
    .valid(vld_q[fill_idx]), .tree(fill_tree_base), .way_sel(fill_way));

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
  end

  // Valid bits and replacement trees: flush wins over everything.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (ctl_flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      if (lk_hit) plru_q[lk_idx] <= plru_after_lk;
      if (fill_we) begin
        vld_q[fill_idx][fill_way] <= 1'b1;
        plru_q[fill_idx]          <= plru_touch(fill_tree_base, fill_way);
      end
    end
  end

  // Tag and instruction storage, written only on an accepted fill.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_idx][fill_way] <= fill_tag;
      d0_q[fill_idx][fill_way]  <= fill_insn0;
      d1_q[fill_idx][fill_way]  <= fill_insn1;
    end
  end

  // Registered lookup result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o   <= 1'b0;
      insn0_o <= '0;
      insn1_o <= '0;
    end else if (lk_hit) begin
      hit_o   <= 1'b1;
      insn0_o <= d0_q[lk_idx][lk_way];
      insn1_o <= d1_q[lk_idx][lk_way];
    end else begin
      hit_o   <= 1'b0;
      insn0_o <= '0;
      insn1_o <= '0;
    end
  end

  // R2: a hit only ever answers a request of the previous cycle
  assert_hit_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(lk_valid));
  // R3: instruction outputs are quiet on a miss
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (insn0_o == '0 && insn1_o == '0));
  // R6: disabled cycles never produce a hit
  assert_disabled_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_disable |=> !hit_o);
  // R7, R8: after a flush nothing is valid, whatever fill came with it
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flush |=> !any_valid);
  // R4: an accepted fill leaves its chosen way valid
  assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> vld_q[$past(fill_idx)][$past(fill_way)]);
endmodule

// File: tb/tgt_insn_cache_tb.sv
`timescale 1ns/1ps
module tgt_insn_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, fill_valid = 0, ctl_disable = 0, ctl_flush = 0;
  logic [31:0] lk_addr = 0, fill_addr = 0, fill_insn0 = 0, fill_insn1 = 0;
  logic        hit_o;
  logic [31:0] insn0_o, insn1_o;

  always #2.5 clk = ~clk;

  tgt_insn_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_insn0(fill_insn0),
    .fill_insn1(fill_insn1), .ctl_disable(ctl_disable), .ctl_flush(ctl_flush),
    .hit_o(hit_o), .insn0_o(insn0_o), .insn1_o(insn1_o));

  typedef struct {
    logic        hit;
    logic [31:0] d0;
    logic [31:0] d1;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference contents, kept the bench's own way.
  bit          m_v [16][4];
  logic [25:0] m_t [16][4];
  logic [31:0] m_a [16][4];
  logic [31:0] m_b [16][4];
  bit          m_left [16];   // next victim lies in ways 0/1
  bit          m_lo1  [16];   // among 0/1 victim is way 1
  bit          m_hi3  [16];   // among 2/3 victim is way 3

  function automatic logic [31:0] mk(int set, int tag);
    return {tag[25:0], set[3:0], 2'b00};
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
      m_left[s] = 1; m_lo1[s] = 0; m_hi3[s] = 0;
    end
  endfunction

  function automatic void m_use(int s, int w);
    case (w)
      0: begin m_left[s] = 0; m_lo1[s] = 1; end
      1: begin m_left[s] = 0; m_lo1[s] = 0; end
      2: begin m_left[s] = 1; m_hi3[s] = 1; end
      default: begin m_left[s] = 1; m_hi3[s] = 0; end
    endcase
  endfunction

  function automatic int m_find(int s, logic [25:0] t);
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_pick(int s, logic [25:0] t);
    int w;
    w = m_find(s, t);
    if (w >= 0) return w;
    for (int k = 0; k < 4; k++) if (!m_v[s][k]) return k;
    if (m_left[s]) return m_lo1[s] ? 1 : 0;
    return m_hi3[s] ? 3 : 2;
  endfunction

  // Driver: one cycle of stimulus; pushes the expected result of the next edge.
  task automatic step(bit lkv, logic [31:0] la, bit fv, logic [31:0] fa,
                      logic [31:0] f0, logic [31:0] f1, bit dis, bit fl, string req);
    exp_t e;
    int ls, lw, fs, fw;
    lk_valid = lkv; lk_addr = la; fill_valid = fv; fill_addr = fa;
    fill_insn0 = f0; fill_insn1 = f1; ctl_disable = dis; ctl_flush = fl;
    ls = int'(la[5:2]);
    lw = m_find(ls, la[31:6]);
    e.req = req; e.hit = 0; e.d0 = 0; e.d1 = 0;
    if (lkv && !dis && lw >= 0) begin
      e.hit = 1; e.d0 = m_a[ls][lw]; e.d1 = m_b[ls][lw];
    end
    exp_q.push_back(e);
    if (fl) m_clear();
    else begin
      if (e.hit) m_use(ls, lw);
      if (fv && !dis) begin
        fs = int'(fa[5:2]);
        fw = m_pick(fs, fa[31:6]);
        m_v[fs][fw] = 1; m_t[fs][fw] = fa[31:6];
        m_a[fs][fw] = f0; m_b[fs][fw] = f1;
        m_use(fs, fw);
      end
    end
    @(negedge clk);
  endtask

  task automatic look(logic [31:0] a, string req);
    step(1, a, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(logic [31:0] a, logic [31:0] d0, logic [31:0] d1, string req);
    step(0, 0, 1, a, d0, d1, 0, 0, req);
  endtask

  // Monitor: compare each registered result just after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (hit_o !== e.hit || insn0_o !== e.d0 || insn1_o !== e.d1) begin
          errors++;
          $display("FAIL %s: hit=%0b d0=%h d1=%h expected hit=%0b d0=%h d1=%h",
                   e.req, hit_o, insn0_o, insn1_o, e.hit, e.d0, e.d1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    // R10: outputs are zero while in reset
    checks++;
    if (hit_o !== 1'b0 || insn0_o !== 32'd0 || insn1_o !== 32'd0) begin
      errors++;
      $display("FAIL R10: hit=%0b d0=%h d1=%h expected hit=0 d0=0 d1=0", hit_o, insn0_o, insn1_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    look(mk(0, 0), "R10");
    look(mk(9, 77), "R10");

    // R3, R1: data returned per address; neighbouring sets stay apart
    fill(mk(3, 1), 32'h1111_0003, 32'h2222_0003, "R3");
    fill(mk(4, 1), 32'h1111_0004, 32'h2222_0004, "R1");
    look(mk(3, 1), "R3");
    look(mk(4, 1), "R1");
    look(mk(5, 1), "R1");
    look(mk(3, 2), "R3");
    // R2: no request, no hit, even right after a hit
    step(0, mk(3, 1), 0, 0, 0, 0, 0, 0, "R2");
    look(mk(3, 1), "R2");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R9: lookup racing a fill of the same address sees the old state
    step(1, mk(6, 9), 1, mk(6, 9), 32'hAAAA_0001, 32'hBBBB_0001, 0, 0, "R9");
    look(mk(6, 9), "R9");

    // R4: refill of a resident tag overwrites it in place
    fill(mk(3, 5), 32'h5, 32'h55, "R4");
    fill(mk(3, 6), 32'h6, 32'h66, "R4");
    fill(mk(3, 1), 32'h1010_1010, 32'h2020_2020, "R4");
    look(mk(3, 1), "R4");
    look(mk(3, 5), "R4");
    look(mk(3, 6), "R4");

    // R5: full set, tree replacement; first-filled way goes first
    for (int t = 1; t <= 4; t++) fill(mk(7, t), 32'h700 + t, 32'h7000 + t, "R5");
    fill(mk(7, 5), 32'h705, 32'h7005, "R5");
    look(mk(7, 1), "R5");
    for (int t = 2; t <= 5; t++) look(mk(7, t), "R5");
    fill(mk(7, 6), 32'h706, 32'h7006, "R5");
    for (int t = 1; t <= 6; t++) look(mk(7, t), "R5");

    // R6: disabled cache misses and ignores fills
    step(1, mk(3, 5), 0, 0, 0, 0, 1, 0, "R6");
    step(0, 0, 1, mk(8, 3), 32'h8, 32'h88, 1, 0, "R6");
    look(mk(8, 3), "R6");
    look(mk(3, 5), "R6");

    // R7: flush empties everything; R9 lookup in flush cycle still hits
    step(1, mk(3, 5), 0, 0, 0, 0, 0, 1, "R9");
    look(mk(3, 5), "R7");
    look(mk(4, 1), "R7");

    // R8: fill arriving with a flush is lost
    step(0, 0, 1, mk(2, 4), 32'h2, 32'h22, 0, 1, "R8");
    look(mk(2, 4), "R8");

    // R5 and the rest under a random mix of small address pools
    for (int i = 0; i < 4000; i++) begin
      int s, t, s2, t2, r;
      s = $urandom_range(0, 3); t = $urandom_range(1, 6);
      s2 = $urandom_range(0, 3); t2 = $urandom_range(1, 6);
      r = $urandom_range(0, 99);
      step($urandom_range(0, 3) != 0, mk(s, t), $urandom_range(0, 2) == 0, mk(s2, t2),
           $urandom, $urandom, r < 3, r == 99, "R5");
    end

    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule